// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address. It reads a first-level directory entry and then, when needed, a second-level table entry through a single-outstanding read port. Memory behind that port is external. A request carries the virtual address, a write flag and a user-mode flag. A root input gives the physical base of the 4 KB directory page.

The walker accepts one translation at a time. While a walk is in progress `busy` is high and new requests are ignored. The walk ends with a one-cycle `done` pulse, which carries one of two results:
- the physical address, or
- a fault flag with a three-bit code. Code bit 0 separates a protection violation (1) from a missing mapping (0). Bit 1 records a write. Bit 2 records a user-mode access.

A directory entry with its page-size bit set maps a 4 MB page directly and ends the walk at the first level.

Top module: `pgwalk_top`

## Requirements
- R1: The first read of a walk goes to `(root_base & ~0xFFF) + vaddr[31:22]*4`. Bits 11..0 of `root_base` have no effect.
- R2: The directory entry may be present (bit 0 = 1) with bit 7 clear. Then exactly one more read is issued, at `{dir[31:12],12'h000} + vaddr[21:12]*4`, and no walk issues more than two reads.
- R3: A successful 4 KB walk returns `done_paddr = {tbl[31:12], vaddr[11:0]}`.
- R4: A present directory entry with bit 7 set ends the walk after one read. It returns `{dir[31:22], vaddr[21:0]}`, and directory bits 21..12 have no effect.
- R5: An entry with bit 0 clear at either level gives `done_fault=1` with code bit 0 = 0. No read follows it.
- R6: On every fault, code bit 1 equals the request's write flag and code bit 2 equals its user flag.
- R7: A user-mode access faults with code bit 0 = 1 unless bit 2 is set in every entry of the walk. A user-mode write also needs bit 1 set in every entry of the walk.
- R8: A supervisor access to a present mapping never faults. Bits 1 and 2 of the entries have no effect on it.
- R9: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle on, and `req_valid` is ignored while `busy` is high.
- R10: `done` is high for exactly one cycle, and `busy` is low in that cycle. On a fault `done_paddr` is zero.
- R11: The walker waits any number of cycles for `mem_rvalid` after each read request.
- R12: After reset `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Physical base of the directory page (low 12 bits ignored) |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion is a fault |
| done_code | output | 3 | Fault code {user, write, protection} |
| done_paddr | output | 32 | Physical address (zero on fault) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The assertions rely on memory returning exactly one `mem_rvalid` for each `mem_req`. They also rely on it never answering while the walker is idle. The bench memory model meets both: it answers each request once, after a delay of one to three cycles. The bench raises `req_valid` only while idle, or as a single-cycle disturbance while `busy` is high. A sweep over directory entries, table entries, the write flag and the user flag covers every permission combination, missing mappings at both levels and large pages, each with a different root offset.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [1:0] {WK_IDLE, WK_DIR, WK_TBL} wk_state_e;
  localparam int unsigned BIT_PRES = 0;
  localparam int unsigned BIT_RW   = 1;
  localparam int unsigned BIT_US   = 2;
  localparam int unsigned BIT_BIG  = 7;
  localparam int unsigned FC_PROT  = 0;
  localparam int unsigned FC_WR    = 1;
  localparam int unsigned FC_USR   = 2;
endpackage

// File: rtl/pgwalk_ent_addr.sv
module pgwalk_ent_addr #(
  parameter int AW      = 32,
  parameter int OFF_W   = 12,
  parameter int IW      = 10,
  parameter int ENT_LOG = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << OFF_W) - 64'd1);
  logic [AW-1:0] base_al;
  always_comb begin
    base_al = base_i & ~LOW_MASK;
    addr_o  = base_al + (AW'(idx_i) << ENT_LOG);
  end
endmodule

// File: rtl/pgwalk_leaf.sv
module pgwalk_leaf #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [AW-1:0] entry_i,
  input  logic [AW-1:0] vaddr_i,
  output logic [AW-1:0] pa_small_o,
  output logic [AW-1:0] pa_large_o
);
  localparam int BIG_OFF = OFF_W + IDX_W;
  localparam logic [AW-1:0] SMALL_MASK = AW'((64'd1 << OFF_W) - 64'd1);
  localparam logic [AW-1:0] LARGE_MASK = AW'((64'd1 << BIG_OFF) - 64'd1);
  always_comb begin
    pa_small_o = (entry_i & ~SMALL_MASK) | (vaddr_i & SMALL_MASK);
    pa_large_o = (entry_i & ~LARGE_MASK) | (vaddr_i & LARGE_MASK);
  end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
(
  input  logic       pres_i,
  input  logic       rw_i,
  input  logic       us_i,
  input  logic       acc_u_i,
  input  logic       acc_w_i,
  input  logic       leaf_i,
  input  logic       user_i,
  input  logic       write_i,
  output logic       eff_u_o,
  output logic       eff_w_o,
  output logic       fault_o,
  output logic [2:0] code_o
);
  logic deny, prot;
  always_comb begin
    eff_u_o = acc_u_i & us_i;
    eff_w_o = acc_w_i & rw_i;
    // supervisor accesses skip both permission bits
    deny    = user_i & (~eff_u_o | (write_i & ~eff_w_o));
    prot    = pres_i & leaf_i & deny;
    fault_o = ~pres_i | prot;
    code_o  = '0;
    code_o[FC_PROT] = prot;
    code_o[FC_WR]   = write_i;
    code_o[FC_USR]  = user_i;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int ENT_LOG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] root_base,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  input  logic          req_user,
  output logic          busy,
  output logic          done,
  output logic          done_fault,
  output logic [2:0]    done_code,
  output logic [AW-1:0] done_paddr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata
);
  localparam int DIR_W   = AW - OFF_W - IDX_W;
  localparam int BIG_OFF = OFF_W + IDX_W;

  wk_state_e     state;
  logic [AW-1:0] va_q;
  logic          wr_q, us_q, acc_u_q, acc_w_q, big_q;

  logic [AW-1:0] dir_addr, tbl_addr, pa_small, pa_large;
  logic          in_dir, big_hit, leaf, eff_u, eff_w, wfault;
  logic [2:0]    wcode;

  pgwalk_ent_addr #(.AW(AW), .OFF_W(OFF_W), .IW(DIR_W), .ENT_LOG(ENT_LOG)) dir_addr_i (
    .base_i(root_base), .idx_i(req_vaddr[AW-1 -: DIR_W]), .addr_o(dir_addr));

  pgwalk_ent_addr #(.AW(AW), .OFF_W(OFF_W), .IW(IDX_W), .ENT_LOG(ENT_LOG)) tbl_addr_i (
    .base_i(mem_rdata), .idx_i(va_q[BIG_OFF-1 -: IDX_W]), .addr_o(tbl_addr));

  pgwalk_leaf #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) leaf_i (
    .entry_i(mem_rdata), .vaddr_i(va_q), .pa_small_o(pa_small), .pa_large_o(pa_large));

  always_comb begin
    in_dir  = (state == WK_DIR);
    big_hit = in_dir & mem_rdata[BIT_BIG];
    leaf    = big_hit | (state == WK_TBL);
  end

  pgwalk_perm perm_i (
    .pres_i(mem_rdata[BIT_PRES]), .rw_i(mem_rdata[BIT_RW]), .us_i(mem_rdata[BIT_US]),
    .acc_u_i(in_dir ? 1'b1 : acc_u_q), .acc_w_i(in_dir ? 1'b1 : acc_w_q),
    .leaf_i(leaf), .user_i(us_q), .write_i(wr_q),
    .eff_u_o(eff_u), .eff_w_o(eff_w), .fault_o(wfault), .code_o(wcode));

  assign busy = (state != WK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WK_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      acc_u_q    <= 1'b0;
      acc_w_q    <= 1'b0;
      big_q      <= 1'b0;
      done       <= 1'b0;
      done_fault <= 1'b0;
      done_code  <= '0;
      done_paddr <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        WK_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            us_q     <= req_user;
            mem_addr <= dir_addr;
            mem_req  <= 1'b1;
            state    <= WK_DIR;
          end
        end
        WK_DIR: begin
          if (mem_rvalid) begin
            if (wfault || big_hit) begin
              done       <= 1'b1;
              done_fault <= wfault;
              done_code  <= wfault ? wcode : 3'b000;
              done_paddr <= wfault ? '0 : pa_large;
              big_q      <= 1'b1;
              state      <= WK_IDLE;
            end else begin
              acc_u_q  <= eff_u;
              acc_w_q  <= eff_w;
              mem_addr <= tbl_addr;
              mem_req  <= 1'b1;
              state    <= WK_TBL;
            end
          end
        end
        WK_TBL: begin
          if (mem_rvalid) begin
            done       <= 1'b1;
            done_fault <= wfault;
            done_code  <= wfault ? wcode : 3'b000;
            done_paddr <= wfault ? '0 : pa_small;
            big_q      <= 1'b0;
            state      <= WK_IDLE;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  // read requests only while a walk is open
  assert_req_in_walk_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // captured request is frozen for the whole walk
  assert_hold_request_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(va_q));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_fault_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault) |-> (done_code[FC_WR] == wr_q && done_code[FC_USR] == us_q));
  assert_sup_no_prot_R8: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault && !us_q) |-> !done_code[FC_PROT]);
  assert_big_offset_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !done_fault && big_q) |-> done_paddr[BIG_OFF-1:0] == va_q[BIG_OFF-1:0]);
endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy, done, done_fault, mem_req;
  logic [2:0]  done_code;
  logic [31:0] done_paddr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst(rst), .root_base(root_base), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .done(done), .done_fault(done_fault), .done_code(done_code),
    .done_paddr(done_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat = 1;
  int rd_cnt = 0;
  logic [31:0] rd_addr [0:3];
  logic [31:0] mem [0:4095];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "R11", "watchdog", 32'(cycles), 32'd150000);
      finish_run();
    end
  end

  // memory model: one answer per request after lat cycles
  initial forever begin
    @(negedge clk);
    mem_rvalid = 1'b0;
    if (mem_req) begin
      logic [31:0] a;
      a = mem_addr;
      if (rd_cnt < 4) rd_addr[rd_cnt] = a;
      rd_cnt++;
      repeat (lat - 1) @(negedge clk);
      mem_rvalid = 1'b1;
      mem_rdata  = mem[a[13:2]];
    end
  end

  task automatic model(input logic [31:0] va, input logic wr, input logic us,
                       output logic ef, output logic [2:0] ec, output logic [31:0] ep,
                       output int en, output logic [31:0] ea1, output string cat);
    logic [31:0] d, t;
    logic u, w, deny;
    d = mem[12'h400 + {2'b00, va[31:22]}];
    ep = '0; en = 1; ea1 = '0; ef = 1'b0; ec = 3'b000;
    if (!d[0]) begin
      ef = 1'b1; ec = {us, wr, 1'b0}; cat = "R5";
    end else if (d[7]) begin
      deny = us && (!d[2] || (wr && !d[1]));
      cat = us ? "R7" : "R8";
      if (deny) begin ef = 1'b1; ec = {us, wr, 1'b1}; end
      else ep = {d[31:22], va[21:0]};
    end else begin
      ea1 = {d[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      t = mem[ea1[13:2]];
      en = 2;
      if (!t[0]) begin
        ef = 1'b1; ec = {us, wr, 1'b0}; cat = "R5";
      end else begin
        u = d[2] & t[2]; w = d[1] & t[1];
        deny = us && (!u || (wr && !w));
        cat = us ? "R7" : "R8";
        if (deny) begin ef = 1'b1; ec = {us, wr, 1'b1}; end
        else ep = {t[31:12], va[11:0]};
      end
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr, input logic us,
                       input logic [31:0] root, input bit poke);
    logic ef; logic [2:0] ec; logic [31:0] ep, ea1; int en; string cat;
    int wait_n;
    model(va, wr, us, ef, ec, ep, en, ea1, cat);
    rd_cnt = 0;
    @(negedge clk);
    root_base = root; req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
    req_valid = poke;
    if (poke) begin req_vaddr = 32'hFFFF_FFFF; root_base = 32'h0000_3000; end
    wait_n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      wait_n++;
    end while (!done && wait_n < 50);
    chk(done == 1'b1, "R11", "done seen", 32'(done), 32'd1);
    chk(busy == 1'b0, "R10", "busy low at done", 32'(busy), 32'd0);
    chk(done_fault == ef, cat, "fault flag", 32'(done_fault), 32'(ef));
    if (ef) begin
      chk(done_code[0] == ec[0], cat, "code bit0", 32'(done_code), 32'(ec));
      chk(done_code[2:1] == ec[2:1], "R6", "code bits 2:1", 32'(done_code), 32'(ec));
      chk(done_paddr == 32'h0, "R10", "paddr on fault", done_paddr, 32'h0);
    end else begin
      chk(done_paddr == ep, (en == 1) ? "R4" : "R3", "paddr", done_paddr, ep);
    end
    chk(rd_cnt == en, (en == 1) ? "R4" : "R2", "read count", 32'(rd_cnt), 32'(en));
    chk(rd_addr[0] == 32'h1000 + {20'h0, va[31:22], 2'b00}, "R1", "dir read addr",
        rd_addr[0], 32'h1000 + {20'h0, va[31:22], 2'b00});
    if (en == 2 && rd_cnt >= 2)
      chk(rd_addr[1] == ea1, "R2", "table read addr", rd_addr[1], ea1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      if (k[2]) e = {10'(10'h040 + k), 22'h0} | 32'h0015_5080;
      else      e = 32'h0000_2000;
      mem[12'h400 + k] = e | {29'h0, k[1], k[0], 1'b1};
    end
    mem[12'h408] = 32'h0000_2006;
    mem[12'h409] = 32'h0000_3007;
    mem[12'h7FF] = 32'hFFC0_0087;
    for (int j = 0; j < 8; j++) begin
      mem[12'h800 + j] = {20'(20'h50000 + j * 20'h111), 12'h0} | {29'h0, 3'(j)};
      mem[12'hC00 + j] = (j == 5) ? 32'h1234_5007 : 32'h0000_0006;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R12", "busy in reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R12", "done in reset", 32'(done), 32'd0);
    chk(mem_req == 1'b0, "R12", "mem_req in reset", 32'(mem_req), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R12", "idle after reset", 32'(busy), 32'd0);
    begin
      int n = 0;
      for (int di = 0; di < 11; di++) begin
        for (int j = 0; j < 8; j++) begin
          for (int m = 0; m < 4; m++) begin
            logic [9:0]  d;
            logic [31:0] va, root;
            d    = (di == 10) ? 10'h3FF : 10'(di);
            va   = {d, 10'(j), 12'((di * 37 + j * 11 + m * 301) & 12'hFFF)};
            root = 32'h1000 | 32'((di * 32'h155 + m) & 32'hFFF);
            lat  = 1 + (n % 3);
            xlate(va, m[0], m[1], root, (n % 4) == 1);
            n++;
          end
        end
      end
    end
    finish_run();
  end
endmodule